// File: doc/BRIEF.md
# Priority Reference Clock Selector

This block picks one of five candidate reference inputs to act as the main timing reference. Each input carries a validity flag from an upstream quality monitor and a 4-bit priority value. An input is a candidate (qualified) only when it is valid and its priority is non-zero. In automatic operation the block chooses among qualified inputs, either reverting to the best candidate whenever one appears (revertive) or holding on to the current input until it drops out (non-revertive). A manual mode lets control logic pin the selection to a chosen index whatever the qualification says.

Next to the selection, the block reports the three best qualified inputs in rank order. Inputs are numbered 1 to 5 on every index output, and index 0 means "none". Every output is registered. A change on the inputs shows up one clock later.

The control is a three-state machine. HOLD means automatic mode with no qualified input. TRACK means automatic mode with a selected input. FORCED means manual mode. The transitions are evaluated every cycle. Any state goes to FORCED while a manual mode is applied. Any state goes to HOLD when automatic mode finds no qualified input. HOLD or FORCED goes to TRACK by picking the best candidate afresh. TRACK stays in TRACK, keeping its input or switching according to the revertive rules.

Top module: `refsel_top`

## Requirements
- R1: While rst_n is low, sel_idx_o, rank1_o, rank2_o and rank3_o are 0 and holdover_o is 1.
- R2: Input k (1..5) is qualified only when valid_i bit k-1 is 1 and its priority prio_i[4k-1:4k-4] is non-zero. An input with priority 0 is never chosen automatically.
- R3: A smaller non-zero priority value ranks higher. When an automatic switch occurs, the qualified input with the best priority is chosen, and equal priorities go to the smallest index.
- R4: In revertive mode (mode_i = 01), a qualified input whose priority is strictly better than the current input's replaces it. An equal priority at a smaller index does not.
- R5: In non-revertive mode (mode_i = 00), the current input is kept as long as it stays qualified, even if a better input appears.
- R6: In either automatic mode, a current input that becomes disqualified is replaced by the best qualified input.
- R7: In automatic mode with no qualified input, sel_idx_o is 0 and holdover_o is 1.
- R8: In manual modes (mode_i = 10 forced, 11 fast external), sel_idx_o follows force_idx_i regardless of qualification. An index outside 1..5 gives 0. holdover_o is 0 in these modes.
- R9: On a return from manual to automatic mode, the best qualified input is selected, even under non-revertive mode.
- R10: rank1_o, rank2_o and rank3_o name the qualified inputs with the first, second and third best priority, with ties ordered by smaller index.
- R11: Rank outputs with no qualified input left to name are 0.
- R12: All outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 5 | Per-input validity, bit k-1 for input k |
| prio_i | input | 20 | Per-input priority, 4 bits each, input k at [4k-1:4k-4] |
| mode_i | input | 2 | 00 non-revertive, 01 revertive, 10 forced, 11 fast external |
| force_idx_i | input | 4 | Index used in manual modes |
| sel_idx_o | output | 4 | Selected input index, 0 for none |
| holdover_o | output | 1 | High when automatic mode has no qualified input |
| rank1_o | output | 4 | Best qualified input |
| rank2_o | output | 4 | Second-best qualified input |
| rank3_o | output | 4 | Third-best qualified input |

## Verification
The assertions assume that validity, priorities, mode and the forced index are stable around each rising edge and change at most once per cycle. They also assume that the history registers inside the checker match the inputs the design itself sampled, so the one-cycle relation between inputs and outputs is checked against real input values. The stimulus drives every input on the falling edge only. It keeps force_idx_i defined in all modes, and it moves between modes only on cycle boundaries, so the non-revertive hold rule and the re-selection rule on leaving manual mode are exercised with clean histories.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_NONREV = 2'b00,
        MODE_REV    = 2'b01,
        MODE_FORCED = 2'b10,
        MODE_FAST   = 2'b11
    } sel_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'b00,
        ST_TRACK  = 2'b01,
        ST_FORCED = 2'b10
    } sel_state_e;

endpackage

// File: rtl/refsel_qualify.sv
module refsel_qualify #(
    parameter int N_IN   = 5,
    parameter int PRIO_W = 4
) (
    input  logic [N_IN-1:0]        valid_i,
    input  logic [N_IN*PRIO_W-1:0] prio_i,
    output logic [N_IN-1:0]        qual_o
);

    for (genvar g = 0; g < N_IN; g++) begin : g_qual
        assign qual_o[g] = valid_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0);
    end

endmodule

// File: rtl/refsel_rank.sv
module refsel_rank #(
    parameter int N_IN   = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic [N_IN-1:0]        qual_i,
    input  logic [N_IN*PRIO_W-1:0] prio_i,
    output logic [IDX_W-1:0]       top1_o,
    output logic [IDX_W-1:0]       top2_o,
    output logic [IDX_W-1:0]       top3_o
);

    localparam int CNT_W = $clog2(N_IN + 1);

    logic [CNT_W-1:0] place [N_IN];

    // place = number of qualified inputs that beat this one
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_place
        always_comb begin
            place[gi] = '0;
            for (int j = 0; j < N_IN; j++) begin
                if (qual_i[j] && (j != gi)) begin
                    if ((prio_i[j*PRIO_W +: PRIO_W] < prio_i[gi*PRIO_W +: PRIO_W]) ||
                        ((prio_i[j*PRIO_W +: PRIO_W] == prio_i[gi*PRIO_W +: PRIO_W]) && (j < gi))) begin
                        place[gi] = place[gi] + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        top1_o = '0;
        top2_o = '0;
        top3_o = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (qual_i[i]) begin
                if (place[i] == CNT_W'(0)) top1_o = IDX_W'(i + 1);
                if (place[i] == CNT_W'(1)) top2_o = IDX_W'(i + 1);
                if (place[i] == CNT_W'(2)) top3_o = IDX_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int N_IN   = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_i,
    input  logic [IDX_W-1:0]       force_idx_i,
    input  logic [N_IN-1:0]        qual_i,
    input  logic [N_IN*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]       best_i,
    output logic [IDX_W-1:0]       sel_o,
    output logic                   hold_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_IN);

    sel_state_e       state_q, state_n;
    logic [IDX_W-1:0] sel_q, sel_n;
    logic             manual, revertive, force_ok;
    logic             cur_qual;
    logic [PRIO_W-1:0] cur_prio, best_prio;

    assign manual    = mode_i[1];
    assign revertive = (sel_mode_e'(mode_i) == MODE_REV);
    assign force_ok  = (force_idx_i != '0) && (force_idx_i <= LAST_IDX);

    always_comb begin
        cur_qual  = 1'b0;
        cur_prio  = '0;
        best_prio = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel_q == IDX_W'(i + 1)) begin
                cur_qual = qual_i[i];
                cur_prio = prio_i[i*PRIO_W +: PRIO_W];
            end
            if (best_i == IDX_W'(i + 1)) begin
                best_prio = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        state_n = state_q;
        sel_n   = sel_q;
        if (manual) begin
            state_n = ST_FORCED;
            sel_n   = force_ok ? force_idx_i : '0;
        end else if (qual_i == '0) begin
            state_n = ST_HOLD;
            sel_n   = '0;
        end else begin
            state_n = ST_TRACK;
            unique case (state_q)
                ST_HOLD, ST_FORCED: sel_n = best_i;
                ST_TRACK: begin
                    if (!cur_qual) begin
                        sel_n = best_i;
                    end else if (revertive && (best_prio < cur_prio)) begin
                        sel_n = best_i;
                    end else begin
                        sel_n = sel_q;
                    end
                end
                default: sel_n = best_i;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_n;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            hold_o <= 1'b1;
        end else begin
            sel_q  <= sel_n;
            hold_o <= (state_n == ST_HOLD);
        end
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
    parameter int N_IN   = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        valid_i,
    input  logic [N_IN*PRIO_W-1:0] prio_i,
    input  logic [1:0]             mode_i,
    input  logic [IDX_W-1:0]       force_idx_i,
    output logic [IDX_W-1:0]       sel_idx_o,
    output logic                   holdover_o,
    output logic [IDX_W-1:0]       rank1_o,
    output logic [IDX_W-1:0]       rank2_o,
    output logic [IDX_W-1:0]       rank3_o
);

    logic [N_IN-1:0]  qual;
    logic [IDX_W-1:0] top1, top2, top3;

    refsel_qualify #(.N_IN(N_IN), .PRIO_W(PRIO_W)) qualify_i (
        .valid_i (valid_i),
        .prio_i  (prio_i),
        .qual_o  (qual)
    );

    refsel_rank #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) rank_i (
        .qual_i (qual),
        .prio_i (prio_i),
        .top1_o (top1),
        .top2_o (top2),
        .top3_o (top3)
    );

    refsel_fsm #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .force_idx_i (force_idx_i),
        .qual_i      (qual),
        .prio_i      (prio_i),
        .best_i      (top1),
        .sel_o       (sel_idx_o),
        .hold_o      (holdover_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank1_o <= '0;
            rank2_o <= '0;
            rank3_o <= '0;
        end else begin
            rank1_o <= top1;
            rank2_o <= top2;
            rank3_o <= top3;
        end
    end

endmodule

// File: rtl/refsel_sva.sv
module refsel_sva #(
    parameter int N_IN   = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_IN-1:0]        valid_i,
    input logic [N_IN*PRIO_W-1:0] prio_i,
    input logic [1:0]             mode_i,
    input logic [IDX_W-1:0]       force_idx_i,
    input logic [IDX_W-1:0]       sel_idx_o,
    input logic                   holdover_o,
    input logic [IDX_W-1:0]       rank1_o,
    input logic [IDX_W-1:0]       rank2_o,
    input logic [IDX_W-1:0]       rank3_o
);

    function automatic logic idx_qual(input logic [IDX_W-1:0] idx,
                                      input logic [N_IN-1:0] v,
                                      input logic [N_IN*PRIO_W-1:0] p);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (idx == IDX_W'(i + 1)) r = v[i] && (p[i*PRIO_W +: PRIO_W] != '0);
        end
        return r;
    endfunction

    logic [N_IN-1:0]        v_q;
    logic [N_IN*PRIO_W-1:0] p_q;
    logic                   auto_q;
    logic [IDX_W-1:0]       force_exp;

    assign force_exp = ((force_idx_i != '0) && (force_idx_i <= IDX_W'(N_IN))) ? force_idx_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= '0;
            p_q    <= '0;
            auto_q <= 1'b0;
        end else begin
            v_q    <= valid_i;
            p_q    <= prio_i;
            auto_q <= !mode_i[1];
        end
    end

    AST_HOLD_MEANS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        holdover_o |-> (sel_idx_o == '0)); // R7

    AST_AUTO_SEL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && (sel_idx_o != '0)) |-> idx_qual(sel_idx_o, v_q, p_q)); // R2

    AST_MANUAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |=> ((sel_idx_o == $past(force_exp)) && !holdover_o)); // R8

    AST_NONREV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b00) && auto_q && (sel_idx_o != '0) && idx_qual(sel_idx_o, valid_i, prio_i))
        |=> $stable(sel_idx_o)); // R5

    AST_RANK2_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rank2_o != '0) |-> ((rank1_o != '0) && (rank1_o != rank2_o))); // R11

    AST_RANK3_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rank3_o != '0) |-> ((rank2_o != '0) && (rank3_o != rank1_o) && (rank3_o != rank2_o))); // R10

endmodule

bind refsel_top refsel_sva #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) sva_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .prio_i      (prio_i),
    .mode_i      (mode_i),
    .force_idx_i (force_idx_i),
    .sel_idx_o   (sel_idx_o),
    .holdover_o  (holdover_o),
    .rank1_o     (rank1_o),
    .rank2_o     (rank2_o),
    .rank3_o     (rank3_o)
);

// File: tb/refsel_top_tb_top.sv
module refsel_top_tb_top;

    localparam int N  = 5;
    localparam int PW = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [N-1:0]  valid;
    logic [N*PW-1:0] prio;
    logic [1:0]    mode;
    logic [IW-1:0] fidx;
    logic [IW-1:0] sel, r1, r2, r3;
    logic          hold;

    refsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .prio_i(prio),
        .mode_i(mode), .force_idx_i(fidx), .sel_idx_o(sel),
        .holdover_o(hold), .rank1_o(r1), .rank2_o(r2), .rank3_o(r3)
    );

    typedef struct {
        int    sel;
        int    hold;
        int    r1;
        int    r2;
        int    r3;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int m_sel  = 0;
    bit m_forced = 1'b0;

    function automatic int pr(input logic [N*PW-1:0] p, input int k);
        return int'(p[(k-1)*PW +: PW]);
    endfunction

    function automatic bit ok(input logic [N-1:0] v, input logic [N*PW-1:0] p, input int k);
        return (k >= 1) && (k <= N) && v[k-1] && (pr(p, k) != 0);
    endfunction

    // independent ranking: repeated minimum search
    task automatic ranks(input logic [N-1:0] v, input logic [N*PW-1:0] p,
                         output int a, output int b, output int c);
        int pick [3];
        for (int s = 0; s < 3; s++) begin
            int best = 0;
            for (int k = 1; k <= N; k++) begin
                bit used = 1'b0;
                for (int t = 0; t < s; t++) if (pick[t] == k) used = 1'b1;
                if (ok(v, p, k) && !used && (best == 0 || pr(p, k) < pr(p, best))) best = k;
            end
            pick[s] = best;
        end
        a = pick[0]; b = pick[1]; c = pick[2];
    endtask

    task automatic drive(input logic [N-1:0] v, input logic [N*PW-1:0] p,
                         input logic [1:0] md, input int f, input string tag);
        exp_t e;
        int a, b, c;
        @(negedge clk);
        valid = v; prio = p; mode = md; fidx = IW'(f);
        ranks(v, p, a, b, c);
        if (md[1]) begin
            m_sel = (f >= 1 && f <= N) ? f : 0;
            m_forced = 1'b1;
            e.hold = 0;
        end else if (a == 0) begin
            m_sel = 0; m_forced = 1'b0; e.hold = 1;
        end else begin
            if (m_forced || m_sel == 0 || !ok(v, p, m_sel)) m_sel = a;
            else if (md == 2'b01 && pr(p, a) < pr(p, m_sel)) m_sel = a;
            m_forced = 1'b0; e.hold = 0;
        end
        e.sel = m_sel; e.r1 = a; e.r2 = b; e.r3 = c; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(sel) != e.sel || int'(hold) != e.hold || int'(r1) != e.r1 ||
                    int'(r2) != e.r2 || int'(r3) != e.r3) begin
                    fails++;
                    $display("FAIL %s: actual sel=%0d hold=%0d rank=%0d/%0d/%0d expected sel=%0d hold=%0d rank=%0d/%0d/%0d",
                             e.tag, sel, hold, r1, r2, r3, e.sel, e.hold, e.r1, e.r2, e.r3);
                end
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid = '0; prio = '0; mode = 2'b00; fidx = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (sel != 0 || hold != 1'b1 || r1 != 0 || r2 != 0 || r3 != 0) begin
            fails++;
            $display("FAIL R1: actual sel=%0d hold=%0d rank=%0d/%0d/%0d expected sel=0 hold=1 rank=0/0/0",
                     sel, hold, r1, r2, r3);
        end
        rst_n = 1'b1;

        // prio packed {p5,p4,p3,p2,p1}
        drive(5'b11111, {4'd1, 4'd2, 4'd5, 4'd2, 4'd3}, 2'b00, 0, "R3 best pick");
        drive(5'b11111, {4'd1, 4'd2, 4'd5, 4'd2, 4'd3}, 2'b00, 0, "R10 full ranking");
        drive(5'b11111, {4'd0, 4'd2, 4'd0, 4'd2, 4'd0}, 2'b00, 0, "R3 tie to smallest");
        drive(5'b11111, {4'd0, 4'd2, 4'd0, 4'd2, 4'd1}, 2'b00, 0, "R5 nonrev keeps");
        drive(5'b11111, {4'd0, 4'd2, 4'd0, 4'd2, 4'd1}, 2'b00, 0, "R5 nonrev keeps again");
        drive(5'b11111, {4'd0, 4'd2, 4'd0, 4'd2, 4'd1}, 2'b01, 0, "R4 rev preempts");
        drive(5'b00100, {4'd0, 4'd0, 4'd3, 4'd0, 4'd0}, 2'b01, 0, "R6 rev current lost");
        drive(5'b00110, {4'd0, 4'd0, 4'd3, 4'd3, 4'd0}, 2'b01, 0, "R4 equal prio no switch");
        drive(5'b00110, {4'd0, 4'd0, 4'd3, 4'd2, 4'd0}, 2'b01, 0, "R4 strictly better");
        drive(5'b00100, {4'd0, 4'd0, 4'd3, 4'd2, 4'd0}, 2'b00, 0, "R6 nonrev current lost");
        drive(5'b01100, {4'd0, 4'd9, 4'd0, 4'd2, 4'd0}, 2'b00, 0, "R2 zero prio disables");
        drive(5'b01100, {4'd0, 4'd9, 4'd0, 4'd2, 4'd0}, 2'b00, 0, "R11 empty rank slots");
        drive(5'b00000, {4'd1, 4'd1, 4'd1, 4'd1, 4'd1}, 2'b00, 0, "R7 holdover");
        drive(5'b00000, {4'd1, 4'd1, 4'd1, 4'd1, 4'd1}, 2'b01, 0, "R7 holdover rev");
        drive(5'b00000, {4'd1, 4'd1, 4'd1, 4'd1, 4'd1}, 2'b10, 1, "R8 forced unqualified");
        drive(5'b00000, {4'd1, 4'd1, 4'd1, 4'd1, 4'd1}, 2'b11, 7, "R8 fast out of range");
        drive(5'b11111, {4'd4, 4'd3, 4'd3, 4'd1, 4'd2}, 2'b11, 5, "R8 fast in range");
        drive(5'b11111, {4'd4, 4'd3, 4'd3, 4'd1, 4'd2}, 2'b00, 0, "R9 leave manual");
        drive(5'b10111, {4'd4, 4'd3, 4'd3, 4'd1, 4'd2}, 2'b00, 0, "R12 one cycle update");
        drive(5'b10101, {4'd4, 4'd3, 4'd3, 4'd1, 4'd2}, 2'b01, 0, "R12 one cycle update rev");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule